// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder

This block collects thirteen level-sensitive interrupt lines from board devices and turns them into one 4-bit code for a processor's interrupt-level input. Every line has a fixed priority level from 0 (most urgent) to 12. Every line also has a fixed enable bit in a 16-bit mask register. The enable bit's position has no link to the line's priority. Among the lines that are high and enabled, the lowest level wins. That level is inverted (XOR 15) and driven out through a register. When nothing is pending, the output is 0.

Software reaches the block through a 64-byte window of 16-bit registers, using a simple read strobe and a simple write strobe. Besides the mask, the window holds three more registers:
- a general-purpose output port that drives a 16-bit bus;
- a constant identification register;
- a power-off register, whose write raises a one-cycle shutdown request.

Top module: `irq_level_encoder`

## Requirements
- R1: While `rst` is high, and after it falls, the mask register, the output port and `level_out` are all 0. `shutdown_req` and `rdata` are also 0.
- R2: Input `irq_in[k]` carries priority level k. Its enable bit in the mask is fixed. Levels 0 to 12 use mask bits 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0 and 15, in that order. A line qualifies only while its input is high and its enable bit is 1. Nothing latches the input.
- R3: `level_out` equals the smallest qualifying level XOR 15. When no line qualifies, `level_out` is 0. Level 0 therefore gives 15, and level 12 gives 3.
- R4: `level_out` changes exactly one clock edge after a change on `irq_in`, and one edge after the edge that writes the mask.
- R5: The mask is at byte offset 0x00. It is read/write, and all 16 bits are stored.
- R6: A write to offset 0x30 with `wdata[0]` = 1 sets `shutdown_req` high for exactly the one cycle after the write edge. A write to 0x30 with bit 0 clear gives no pulse. Reads of 0x30 return 0.
- R7: Offset 0x32 always reads 0x0010, and writes to it change nothing.
- R8: The output port is at offset 0x36. It is read/write, its value drives `port_out`, and it changes only on a write to 0x36.
- R9: Reads of any other offset return 0. Writes to any other offset leave the mask, the port and `level_out` unchanged.
- R10: `rdata` is registered. It shows the addressed register in the cycle after an edge with `rd_en` high, and 0 after an edge without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 13 | Interrupt lines, index = priority level |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte offset in the window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| level_out | output | 4 | Inverted winning level, 0 when idle |
| port_out | output | 16 | Output port register value |
| shutdown_req | output | 1 | One-cycle power-off request |

## Verification
The encoder is first swept over all 8192 input patterns with every enable bit set. This shows that the lowest level always wins, whatever higher lines are also active. The sweep is repeated with one enable bit cleared per pass, while every line is held high. These passes show that each level is gated by its own mask bit, and by no bit at its priority index. A pass that walks a single high line past masks with exactly one bit set separates the mask-bit mapping from the priority order. Register checks cover the following:
- offsets outside the map, where writes must have no effect;
- writes to the version register, which must be ignored;
- power-off writes with bit 0 both set and clear.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int NUM_SRC = 13;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 6;
  localparam int LVL_W   = 4;

  localparam logic [ADDR_W-1:0] OFS_MASK = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_PWR  = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_ID   = 6'h32;
  localparam logic [ADDR_W-1:0] OFS_PORT = 6'h36;
  localparam logic [DATA_W-1:0] ID_VALUE = 16'h0010;

  // enable-bit position of the source with priority level lvl
  function automatic int src_mask_bit(input int lvl);
    case (lvl)
      0:  return 11;
      1:  return 9;
      2:  return 8;
      3:  return 12;
      4:  return 10;
      5:  return 6;
      6:  return 5;
      7:  return 4;
      8:  return 7;
      9:  return 14;
      10: return 13;
      11: return 0;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify
  import irq_enc_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int DW    = DATA_W
) (
  input  logic [N_SRC-1:0] irq_in,
  input  logic [DW-1:0]    enable,
  output logic [N_SRC-1:0] qual
);
  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    localparam int BIT = src_mask_bit(k);
    assign qual[k] = irq_in[k] & enable[BIT];
  end
endmodule

// File: rtl/level_select.sv
module level_select
  import irq_enc_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int LW    = LVL_W
) (
  input  logic [N_SRC-1:0] qual,
  output logic [LW-1:0]    code
);
  logic [LW-1:0] win;

  always_comb begin
    win = '1;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (qual[k]) win = LW'(k);
    end
    code = win ^ {LW{1'b1}};
  end
endmodule

// File: rtl/reg_window.sv
module reg_window
  import irq_enc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] port_q,
  output logic          shutdown
);
  logic [DW-1:0] rd_sel;

  always_comb begin
    case (addr)
      OFS_MASK: rd_sel = mask_q;
      OFS_PORT: rd_sel = port_q;
      OFS_ID:   rd_sel = ID_VALUE;
      default:  rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      port_q   <= '0;
      shutdown <= 1'b0;
      rdata    <= '0;
    end else begin
      shutdown <= wr_en && (addr == OFS_PWR) && wdata[0];
      rdata    <= rd_en ? rd_sel : '0;
      if (wr_en && addr == OFS_MASK) mask_q <= wdata;
      if (wr_en && addr == OFS_PORT) port_q <= wdata;
    end
  end

  AST_SHUTDOWN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    shutdown |-> $past(wr_en && addr == OFS_PWR && wdata[0])); // R6
  AST_ID_READ: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && addr == OFS_ID) |-> rdata == ID_VALUE); // R7
  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && addr == OFS_PORT) |-> $stable(port_q)); // R8
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && addr == OFS_MASK) |-> $stable(mask_q)); // R5
  AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> rdata == '0); // R10
endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder
  import irq_enc_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W,
  parameter int LW    = LVL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [LW-1:0]    level_out,
  output logic [DW-1:0]    port_out,
  output logic             shutdown_req
);
  logic [DW-1:0]    mask_q;
  logic [N_SRC-1:0] qual;
  logic [LW-1:0]    code;

  reg_window #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .mask_q(mask_q), .port_q(port_out),
    .shutdown(shutdown_req)
  );

  irq_qualify #(.N_SRC(N_SRC), .DW(DW)) u_qual (
    .irq_in(irq_in), .enable(mask_q), .qual(qual)
  );

  level_select #(.N_SRC(N_SRC), .LW(LW)) u_sel (
    .qual(qual), .code(code)
  );

  always_ff @(posedge clk) begin
    if (rst) level_out <= '0;
    else     level_out <= code;
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(irq_in) == '0 |-> level_out == '0); // R3
  AST_NO_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(mask_q) == '0 |-> level_out == '0); // R2
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    level_out == '0 || level_out >= LW'(16 - N_SRC)); // R3
  AST_LEVEL_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $stable(irq_in) && $stable(mask_q) |=> $stable(level_out)); // R4
endmodule

// File: tb/sim_irq_level_encoder.sv
`timescale 1ns/1ps
module sim_irq_level_encoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] irq_in = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, port_out;
  logic [3:0]  level_out;
  logic        shutdown_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_level_encoder u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .level_out(level_out),
    .port_out(port_out), .shutdown_req(shutdown_req)
  );

  function automatic int bit_of(input int lvl);
    case (lvl)
      0: return 11; 1: return 9; 2: return 8; 3: return 12; 4: return 10;
      5: return 6;  6: return 5; 7: return 4; 8: return 7;  9: return 14;
      10: return 13; 11: return 0; default: return 15;
    endcase
  endfunction

  function automatic logic [3:0] exp_level(input logic [12:0] irq, input logic [15:0] m);
    for (int k = 0; k < 13; k++)
      if (irq[k] && m[bit_of(k)]) return 4'(k) ^ 4'hF;
    return 4'h0;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up();
  end

  initial begin
    logic [15:0] d;
    logic [15:0] m;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 level", 16'(level_out), 16'h0);
    check("R1 port", port_out, 16'h0);
    check("R1 shutdown", 16'(shutdown_req), 16'h0);
    rst = 1'b0;
    @(negedge clk);
    rd(6'h00, d); check("R1 mask", d, 16'h0);
    irq_in = '1; @(negedge clk);
    check("R2 all masked", 16'(level_out), 16'h0);

    // R5 mask read/write, R4 mask latency
    wr(6'h00, 16'hFFFF);
    check("R4 before mask edge", 16'(level_out), 16'h0);
    @(negedge clk);
    check("R4 after mask edge", 16'(level_out), 16'hF);
    rd(6'h00, d); check("R5 mask rd", d, 16'hFFFF);

    // R3 exhaustive input sweep, full mask
    for (int p = 0; p < 8192; p++) begin
      irq_in = 13'(p);
      @(negedge clk);
      check("R3 sweep", 16'(level_out), 16'(exp_level(13'(p), 16'hFFFF)));
    end

    // R2 one enable bit cleared per pass, all lines high
    irq_in = '1;
    for (int b = 0; b < 16; b++) begin
      m = 16'hFFFF & ~(16'h1 << b);
      wr(6'h00, m);
      @(negedge clk);
      check("R2 clear bit", 16'(level_out), 16'(exp_level(13'h1FFF, m)));
    end

    // R2 single line against single-bit masks
    for (int k = 0; k < 13; k++) begin
      for (int b = 0; b < 16; b++) begin
        wr(6'h00, 16'h1 << b);
        irq_in = 13'h1 << k;
        @(negedge clk);
        check("R2 single", 16'(level_out), 16'(exp_level(13'h1 << k, 16'h1 << b)));
      end
    end

    // R4 input latency
    wr(6'h00, 16'hFFFF);
    irq_in = 13'h1000; @(negedge clk);
    check("R4 settle", 16'(level_out), 16'h3);
    irq_in = 13'h0001;
    check("R4 no early change", 16'(level_out), 16'h3);
    @(negedge clk);
    check("R4 one edge", 16'(level_out), 16'hF);

    // R8 output port
    wr(6'h36, 16'hA5C3);
    check("R8 port out", port_out, 16'hA5C3);
    rd(6'h36, d); check("R8 port rd", d, 16'hA5C3);

    // R7 identification register
    wr(6'h32, 16'h1234);
    rd(6'h32, d); check("R7 id", d, 16'h0010);

    // R9 other offsets
    for (int a = 0; a < 64; a += 2) begin
      if (a != 'h00 && a != 'h30 && a != 'h32 && a != 'h36) begin
        wr(6'(a), 16'h0000);
        rd(6'(a), d); check("R9 read zero", d, 16'h0);
      end
    end
    check("R9 mask kept", 16'(level_out), 16'hF);
    check("R9 port kept", port_out, 16'hA5C3);
    rd(6'h00, d); check("R9 mask rd", d, 16'hFFFF);

    // R6 power-off
    rd(6'h30, d); check("R6 read zero", d, 16'h0);
    wr_en = 1'b1; addr = 6'h30; wdata = 16'h0001;
    @(negedge clk); wr_en = 1'b0;
    check("R6 pulse", 16'(shutdown_req), 16'h1);
    @(negedge clk);
    check("R6 pulse ends", 16'(shutdown_req), 16'h0);
    wr(6'h30, 16'hFFFE);
    check("R6 bit0 clear", 16'(shutdown_req), 16'h0);

    // R10 rdata returns to zero
    @(negedge clk);
    check("R10 idle rdata", rdata, 16'h0);

    // R1 reset again
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R1 re-reset level", 16'(level_out), 16'h0);
    check("R1 re-reset port", port_out, 16'h0);
    finish_up();
  end
endmodule